// File: doc/BRIEF.md
# Differential Phase-Step Dibit Decoder

This block turns a stream of received symbol phases into the bit stream they carry. A phase-estimation stage upstream presents one quantized phase per symbol, on a valid/ready handshake, as an index in units of one eighth of a turn (45°). The block subtracts the phase of the previous accepted symbol modulo one turn. It maps that step back to a Gray-coded dibit and shifts the two bits out on consecutive cycles.

The information lies only in the step between symbols. A constant rotation of the whole received constellation therefore leaves the output unchanged, and no phase-locked reference is needed. An even step (0°, ±90°, 180°) cannot come from a correct transmitter. Such a step is reported on an error flag for that symbol, and decoding continues from its phase.

Top module: `dphase_dibit_dec`

## Requirements
- R1: After reset, and on any symbol accepted with `pktStart` high, the symbol only loads the reference phase and no bit is emitted (`bitValid` stays 0).
- R2: The step is current minus reference, modulo 8, in 45° units. Step 1 (+45°) decodes to dibit 00, step 3 (+135°) to 01, step 5 (−135°) to 11 and step 7 (−45°) to 10. A bit value of 1 on `bitData` means binary 1.
- R3: Adding the same constant modulo 8 to every phase of a packet leaves the decoded bits unchanged.
- R4: A step of 0, 2, 4 or 6 raises `stepErr` during the first-bit cycle of that symbol. Both bits of that symbol are 0, and its phase still becomes the new reference.
- R5: A symbol accepted at clock edge k gives its first (most significant) bit with `bitValid` high in the cycle after edge k. Its second bit follows in the next cycle.
- R6: `symReady` is low only during the first-bit cycle. A symbol presented in that cycle is ignored and does not affect the reference.
- R7: While reset is held, `bitValid` and `stepErr` are 0 and `symReady` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | A symbol phase is offered |
| symPhase | input | PHASE_W | Quantized phase, 45° per step at PHASE_W=3 |
| pktStart | input | 1 | Offered symbol opens a packet (reference only) |
| symReady | output | 1 | Symbol is accepted on this edge when valid |
| bitValid | output | 1 | `bitData` carries a decoded bit |
| bitData | output | 1 | Decoded bit, most significant of the dibit first |
| stepErr | output | 1 | Illegal (even) phase step for the current symbol |

## Verification
The assertions assume that the upstream stage respects the handshake. Only symbols offered while `symReady` is high count, so no step is ever lost or duplicated. They also assume that `pktStart` has meaning only together with `symValid`. The stimulus offers each symbol at a falling edge and withdraws it once it has been taken. In one test it deliberately offers a symbol while ready is low, to show that the symbol is dropped. All phases stay within the index width, so every step that the checks compute modulo 8 is the one the design sees.

// File: rtl/dphase_pkg.sv
package dphase_pkg;

  typedef struct packed {
    logic takeRef;   // latch the offered phase as new reference
    logic decode;    // compute and hold a dibit for this symbol
    logic showMsb;   // first bit cycle
    logic showLsb;   // second bit cycle
  } dphaseStrobe_t;

  // octant step (1 of 8 per turn) to Gray dibit; even steps are illegal
  function automatic logic [1:0] octantToDibit(input logic [2:0] oct);
    logic [1:0] d;
    case (oct)
      3'd1:    d = 2'b00;
      3'd3:    d = 2'b01;
      3'd5:    d = 2'b11;
      3'd7:    d = 2'b10;
      default: d = 2'b00;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/dphase_ctrl.sv
module dphase_ctrl
  import dphase_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          symValid,
  input  logic          pktStart,
  output logic          symReady,
  output dphaseStrobe_t strb
);

  logic haveRef;
  logic msbPhase;
  logic lsbPhase;
  logic accept;

  assign symReady = ~msbPhase;
  assign accept   = symValid & symReady;

  always_comb begin
    strb         = '0;
    strb.takeRef = accept;
    strb.decode  = accept & haveRef & ~pktStart;
    strb.showMsb = msbPhase;
    strb.showLsb = lsbPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveRef  <= 1'b0;
      msbPhase <= 1'b0;
      lsbPhase <= 1'b0;
    end else begin
      if (accept) haveRef <= 1'b1;
      msbPhase <= strb.decode;
      lsbPhase <= msbPhase;
    end
  end

  AST_MSB_THEN_LSB: assert property (@(posedge clk) disable iff (!rstN)
    msbPhase |=> (lsbPhase && !msbPhase)) else $error("msb not followed by lsb"); // R5

  AST_NO_BITS_ON_REF: assert property (@(posedge clk) disable iff (!rstN)
    (accept && pktStart) |=> !msbPhase) else $error("bits on reference symbol"); // R1

endmodule

// File: rtl/dphase_dp.sv
module dphase_dp
  import dphase_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] symPhase,
  input  dphaseStrobe_t      strb,
  output logic               bitValid,
  output logic               bitData,
  output logic               stepErr
);

  localparam int FINE_W = PHASE_W - 3;

  logic [PHASE_W-1:0] refPhase;
  logic [PHASE_W-1:0] stepRaw;
  logic [2:0]         octant;
  logic               fineBad;
  logic               stepIllegal;
  logic [1:0]         dibitReg;
  logic               errReg;

  assign stepRaw = symPhase - refPhase;
  assign octant  = stepRaw[PHASE_W-1 -: 3];

  generate
    if (FINE_W > 0) begin : g_fine
      assign fineBad = |stepRaw[FINE_W-1:0];
    end else begin : g_exact
      assign fineBad = 1'b0;
    end
  endgenerate

  assign stepIllegal = fineBad | ~octant[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPhase <= '0;
      dibitReg <= 2'b00;
      errReg   <= 1'b0;
    end else begin
      if (strb.takeRef) refPhase <= symPhase;
      if (strb.decode) begin
        dibitReg <= stepIllegal ? 2'b00 : octantToDibit(octant);
        errReg   <= stepIllegal;
      end
    end
  end

  assign bitValid = strb.showMsb | strb.showLsb;
  assign bitData  = strb.showMsb ? dibitReg[1] : (strb.showLsb & dibitReg[0]);
  assign stepErr  = strb.showMsb & errReg;

  AST_ERR_ZERO_DIBIT: assert property (@(posedge clk) disable iff (!rstN)
    stepErr |-> (!bitData ##1 !bitData)) else $error("flagged symbol not 00"); // R4

  AST_ERR_FIRST_BIT: assert property (@(posedge clk) disable iff (!rstN)
    stepErr |-> bitValid) else $error("error outside bit cycle"); // R4

endmodule

// File: rtl/dphase_dibit_dec.sv
module dphase_dibit_dec
  import dphase_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               symValid,
  input  logic [PHASE_W-1:0] symPhase,
  input  logic               pktStart,
  output logic               symReady,
  output logic               bitValid,
  output logic               bitData,
  output logic               stepErr
);

  dphaseStrobe_t strb;

  dphase_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .pktStart (pktStart),
    .symReady (symReady),
    .strb     (strb)
  );

  dphase_dp #(.PHASE_W(PHASE_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .symPhase (symPhase),
    .strb     (strb),
    .bitValid (bitValid),
    .bitData  (bitData),
    .stepErr  (stepErr)
  );

  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    !symReady |=> symReady) else $error("ready low twice"); // R6

  AST_READY_LOW_WITH_BITS: assert property (@(posedge clk) disable iff (!rstN)
    !symReady |-> bitValid) else $error("ready low without bit"); // R6

  AST_PAIR_OF_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !symReady) |=> (bitValid && symReady)) else $error("second bit missing"); // R5

endmodule

// File: tb/dphase_dibit_dec_tb_top.sv
module dphase_dibit_dec_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       symValid;
  logic [2:0] symPhase;
  logic       pktStart;
  logic       symReady, bitValid, bitData, stepErr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dphase_dibit_dec #(.PHASE_W(3)) dut_i (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symPhase(symPhase),
    .pktStart(pktStart), .symReady(symReady), .bitValid(bitValid),
    .bitData(bitData), .stepErr(stepErr)
  );

  // {pkt, phase[2:0], expectBits, dibit[1:0], err}
  localparam int NVEC = 15;
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 1'b0, 2'b00, 1'b0},
    {1'b0, 3'd1, 1'b1, 2'b00, 1'b0},
    {1'b0, 3'd4, 1'b1, 2'b01, 1'b0},
    {1'b0, 3'd1, 1'b1, 2'b11, 1'b0},
    {1'b0, 3'd0, 1'b1, 2'b10, 1'b0},
    {1'b0, 3'd2, 1'b1, 2'b00, 1'b1},
    {1'b0, 3'd6, 1'b1, 2'b00, 1'b1},
    {1'b0, 3'd6, 1'b1, 2'b00, 1'b1},
    {1'b0, 3'd4, 1'b1, 2'b00, 1'b1},
    {1'b1, 3'd5, 1'b0, 2'b00, 1'b0},
    {1'b0, 3'd6, 1'b1, 2'b00, 1'b0},
    {1'b0, 3'd1, 1'b1, 2'b01, 1'b0},
    {1'b0, 3'd6, 1'b1, 2'b11, 1'b0},
    {1'b0, 3'd5, 1'b1, 2'b10, 1'b0},
    {1'b0, 3'd7, 1'b1, 2'b00, 1'b1}
  };

  task automatic chk(input logic cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // offer one symbol for one cycle, then check its output cycles
  task automatic sendSym(input logic pkt, input logic [2:0] ph, input logic hasBits,
                         input logic [1:0] dib, input logic err, input string req);
    @(negedge clk);
    symValid = 1'b1; symPhase = ph; pktStart = pkt;
    @(negedge clk);
    symValid = 1'b0; pktStart = 1'b0;
    if (!hasBits) begin
      chk(bitValid == 1'b0, req, "bitValid on reference symbol", bitValid, 0);
    end else begin
      chk(bitValid && !symReady && bitData == dib[1] && stepErr == err, req,
          "first bit {valid,ready,data,err}",
          {bitValid, symReady, bitData, stepErr}, {2'b10, dib[1], err});
      @(negedge clk);
      chk(bitValid && symReady && bitData == dib[0] && !stepErr, req,
          "second bit {valid,ready,data,err}",
          {bitValid, symReady, bitData, stepErr}, {2'b11, dib[0], 1'b0});
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; symValid = 1'b0; symPhase = '0; pktStart = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(!bitValid && !stepErr && symReady, "R7", "reset {valid,err,ready}",
        {bitValid, stepErr, symReady}, 3'b001);
    @(negedge clk);
    rstN = 1'b1;

    // R1/R2/R3/R4/R5 table walk; second packet is the first rotated by 5
    for (int i = 0; i < NVEC; i++) begin
      sendSym(VEC[i][7], VEC[i][6:4], VEC[i][3], VEC[i][2:1], VEC[i][0],
              VEC[i][0] ? "R4" : (i >= 9 ? "R3" : "R2"));
    end

    // R4 flagged symbol updated the reference: 7 then 0 is step 1 -> 00
    sendSym(1'b0, 3'd0, 1'b1, 2'b00, 1'b0, "R4");

    // R1 first symbol after reset without pktStart only loads reference
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    sendSym(1'b0, 3'd3, 1'b0, 2'b00, 1'b0, "R1");
    sendSym(1'b0, 3'd6, 1'b1, 2'b01, 1'b0, "R1");

    // R6 symbol offered while ready is low is ignored
    @(negedge clk);
    symValid = 1'b1; symPhase = 3'd7; pktStart = 1'b0; // step 1 from 6
    @(negedge clk);
    chk(!symReady && bitValid && bitData == 1'b0, "R6", "ready low in first bit",
        {symReady, bitValid, bitData}, 3'b010);
    symPhase = 3'd0;                                   // must be dropped
    @(negedge clk);
    chk(symReady && bitValid && bitData == 1'b0, "R5", "second bit of step 1",
        {symReady, bitValid, bitData}, 3'b110);
    symPhase = 3'd2;                                   // step 3 from 7 -> 01
    @(negedge clk);
    symValid = 1'b0;
    chk(bitValid && bitData == 1'b0 && !stepErr, "R6", "msb after ignored symbol",
        {bitValid, bitData, stepErr}, 3'b100);
    @(negedge clk);
    chk(bitValid && bitData == 1'b1, "R6", "lsb after ignored symbol",
        {bitValid, bitData}, 2'b11);
    @(negedge clk);
    chk(!bitValid, "R5", "idle after dibit", bitValid, 0);

    // R1 pktStart mid-stream reloads the reference
    sendSym(1'b1, 3'd4, 1'b0, 2'b00, 1'b0, "R1");
    sendSym(1'b0, 3'd3, 1'b1, 2'b10, 1'b0, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule